// File: doc/BRIEF.md
# Overdrive Response Time Compensator

This block sits in the pixel path of an LCD panel timing controller and speeds up the liquid crystal's move between gray levels. For every color component of every active pixel it takes the gray level arriving now and the gray level the same pixel had one frame earlier. An external frame store supplies the earlier value, already aligned with the current pixel. The pair selects a neighbourhood in a 16x16 grid of boost values held in an external register bank. The block blends the four surrounding grid values bilinearly, using the low bits of both gray levels as weights. It then clamps the result to the legal gray range and sends it on in place of the current value.

Display enable and both sync signals travel through the same number of registers as the data, so the compensated stream stays framed exactly as the input stream was. Compensation can be switched off at any time without changing the latency. It is also held off on its own after reset until a new frame begins, because the frame store holds nothing valid until then. Components of 8 or 6 bits are supported, selected by a mode input.

Top module: `overdrive_comp`

## Requirements
- R1: `deOut`, `hsOut` and `vsOut` equal `deIn`, `hsIn` and `vsIn` delayed by exactly 3 clock cycles. `outPix` belongs to the input pixel of that same cycle.
- R2: In any cycle where `deOut` is low, `outPix` is all zero.
- R3: Component k of a pixel occupies bits [8k+7:8k] (k = 0, 1, 2). One cycle after a pixel is accepted, the block reads four grid nodes for each component. Read lane n = 4k + j is `lutAddr[8n+7:8n]`, and its data is `lutData[10n+9:10n]`, a two's-complement value that the bank returns combinationally. An address is {P, C}, with P in bits 7:4. P and C are the upper 4 bits of the normalized previous and current values. Corner j = 0 reads (P, C), j = 1 reads (P+1, C), j = 2 reads (P, C+1) and j = 3 reads (P+1, C+1), where an index of 15 plus one stays at 15.
- R4: With fp and fc the low 4 bits of the normalized previous and current values, the result is computed as follows. top = V0*(16-fc) + V2*fc and bot = V1*(16-fc) + V3*fc. The result is (top*(16-fp) + bot*fp + 128) shifted right arithmetically by 8.
- R5: The interpolated value is clamped: a negative result gives 0, and a result above 255 gives 255.
- R6: When the normalized current and previous values of a component are equal, the current value is output unchanged.
- R7: While `enIn` is low at input time, every component of an active pixel is output unchanged, still 3 cycles later.
- R8: After reset, every pixel is passed unchanged until `vsIn` has been seen rising, that is, high in a cycle after a low cycle. Pixels accepted after that cycle are compensated.
- R9: With `depth6In` high, only bits [5:0] of each input component count. The value is normalized by shifting left 2 places, processed, and shifted right 2 places on output. Output bits [7:6] of each component are then zero.
- R10: While `rstN` is low, all outputs except `lutAddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Compensation enable, sampled with each pixel |
| depth6In | input | 1 | 1 selects 6-bit components, 0 selects 8-bit |
| deIn | input | 1 | Display enable of the incoming pixel |
| hsIn | input | 1 | Horizontal sync in |
| vsIn | input | 1 | Vertical sync in |
| curPix | input | 24 | Current-frame pixel, three components |
| prevPix | input | 24 | Same pixel from the previous frame |
| lutAddr | output | 96 | Twelve grid read addresses, 8 bits each |
| lutData | input | 120 | Twelve grid values, 10-bit signed each |
| deOut | output | 1 | Delayed display enable |
| hsOut | output | 1 | Delayed horizontal sync |
| vsOut | output | 1 | Delayed vertical sync |
| outPix | output | 24 | Compensated pixel |

## Verification
The hardest state to reach is the moment the block first leaves its start-up bypass. It is the only one-time transition, and nothing at the ports shows it except the data that follows. The stimulus sends unequal current and previous values before any frame start, pulses vertical sync, and then repeats values of the same kind, so a bypass that ends too early, too late or never shows up in the data. The clamp corners are reached by choosing gray pairs at opposite ends of the range, where the bench's grid content drives the blend outside 0..255 in both directions.

// File: rtl/odc_pkg.sv
package odc_pkg;
  localparam int PIPE_LAT = 3;
  localparam int CORNERS  = 4;

  typedef struct packed {
    logic de;
    logic pass;
    logic mode6;
  } odc_stb_t;
endpackage

// File: rtl/odc_ctrl.sv
module odc_ctrl
  import odc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enIn,
  input  logic     depth6In,
  input  logic     deIn,
  input  logic     hsIn,
  input  logic     vsIn,
  output odc_stb_t stb1,
  output odc_stb_t stb2,
  output logic     deOut,
  output logic     hsOut,
  output logic     vsOut
);
  logic [PIPE_LAT-1:0] dePipe, hsPipe, vsPipe;
  logic vsPrev, armed;

  // start-up bypass: released by the first rising vertical sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsPrev <= 1'b0;
      armed  <= 1'b0;
    end else begin
      vsPrev <= vsIn;
      if (vsIn && !vsPrev) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb1 <= '0;
      stb2 <= '0;
    end else begin
      stb1.de    <= deIn;
      stb1.pass  <= !enIn || !armed;
      stb1.mode6 <= depth6In;
      stb2       <= stb1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dePipe <= '0;
      hsPipe <= '0;
      vsPipe <= '0;
    end else begin
      dePipe <= {dePipe[PIPE_LAT-2:0], deIn};
      hsPipe <= {hsPipe[PIPE_LAT-2:0], hsIn};
      vsPipe <= {vsPipe[PIPE_LAT-2:0], vsIn};
    end
  end

  assign deOut = dePipe[PIPE_LAT-1];
  assign hsOut = hsPipe[PIPE_LAT-1];
  assign vsOut = vsPipe[PIPE_LAT-1];
endmodule

// File: rtl/odc_datapath.sv
module odc_datapath
  import odc_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int LOW_W  = 6,
  parameter int NCOMP  = 3,
  parameter int IDX_W  = 4,
  parameter int LUT_W  = 10
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  odc_stb_t                                 stb1,
  input  odc_stb_t                                 stb2,
  input  logic [NCOMP*COMP_W-1:0]                  curPix,
  input  logic [NCOMP*COMP_W-1:0]                  prevPix,
  output logic [NCOMP*CORNERS*2*IDX_W-1:0]         lutAddr,
  input  logic [NCOMP*CORNERS*LUT_W-1:0]           lutData,
  output logic [NCOMP*COMP_W-1:0]                  outPix
);
  localparam int FRAC_W = COMP_W - IDX_W;
  localparam int SHIFT  = COMP_W - LOW_W;
  localparam int ADDR_W = 2 * IDX_W;
  localparam int ACC_W  = LUT_W + 2 * FRAC_W + 2;
  localparam int ONE    = 1 << FRAC_W;
  localparam logic signed [ACC_W-1:0] HALF_S = ACC_W'(1 << (2 * FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAX_S  = ACC_W'((1 << COMP_W) - 1);
  localparam logic [IDX_W-1:0] IDX_TOP = '1;

  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    logic [COMP_W-1:0] curS1, prevS1, curN, prevN;
    logic [IDX_W-1:0]  pIdx, cIdx, pIdx1, cIdx1;
    logic signed [LUT_W-1:0] node2 [CORNERS];
    logic [FRAC_W-1:0] fp2, fc2;
    logic [COMP_W-1:0] cur2;
    logic              eq2;
    logic signed [ACC_W-1:0] wC0, wC1, wP0, wP1, top, bot, acc, rnd;
    logic [COMP_W-1:0] clip, pick, res, outLane;

    // stage 1: capture the pixel pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curS1  <= '0;
        prevS1 <= '0;
      end else begin
        curS1  <= curPix[k*COMP_W +: COMP_W];
        prevS1 <= prevPix[k*COMP_W +: COMP_W];
      end
    end

    assign curN  = stb1.mode6 ? (curS1 << SHIFT)  : curS1;
    assign prevN = stb1.mode6 ? (prevS1 << SHIFT) : prevS1;
    assign pIdx  = prevN[COMP_W-1 -: IDX_W];
    assign cIdx  = curN[COMP_W-1 -: IDX_W];
    assign pIdx1 = (pIdx == IDX_TOP) ? pIdx : pIdx + 1'b1;
    assign cIdx1 = (cIdx == IDX_TOP) ? cIdx : cIdx + 1'b1;

    assign lutAddr[(k*CORNERS+0)*ADDR_W +: ADDR_W] = {pIdx,  cIdx};
    assign lutAddr[(k*CORNERS+1)*ADDR_W +: ADDR_W] = {pIdx1, cIdx};
    assign lutAddr[(k*CORNERS+2)*ADDR_W +: ADDR_W] = {pIdx,  cIdx1};
    assign lutAddr[(k*CORNERS+3)*ADDR_W +: ADDR_W] = {pIdx1, cIdx1};

    // stage 2: capture grid nodes and weights
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int j = 0; j < CORNERS; j++) node2[j] <= '0;
        fp2  <= '0;
        fc2  <= '0;
        cur2 <= '0;
        eq2  <= 1'b0;
      end else begin
        for (int j = 0; j < CORNERS; j++)
          node2[j] <= $signed(lutData[(k*CORNERS+j)*LUT_W +: LUT_W]);
        fp2  <= prevN[FRAC_W-1:0];
        fc2  <= curN[FRAC_W-1:0];
        cur2 <= curN;
        eq2  <= (curN == prevN);
      end
    end

    assign wC1 = ACC_W'(fc2);
    assign wC0 = ACC_W'(ONE) - wC1;
    assign wP1 = ACC_W'(fp2);
    assign wP0 = ACC_W'(ONE) - wP1;
    assign top = ACC_W'(node2[0]) * wC0 + ACC_W'(node2[2]) * wC1;
    assign bot = ACC_W'(node2[1]) * wC0 + ACC_W'(node2[3]) * wC1;
    assign acc = top * wP0 + bot * wP1;
    assign rnd = (acc + HALF_S) >>> (2 * FRAC_W);

    always_comb begin
      if (rnd < 0)           clip = '0;
      else if (rnd > MAX_S)  clip = '1;
      else                   clip = rnd[COMP_W-1:0];
      pick = (stb2.pass || eq2) ? cur2 : clip;
      if (!stb2.de)          res = '0;
      else if (stb2.mode6)   res = pick >> SHIFT;
      else                   res = pick;
    end

    // stage 3: output register
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outLane <= '0;
      else       outLane <= res;
    end

    assign outPix[k*COMP_W +: COMP_W] = outLane;
  end
endmodule

// File: rtl/overdrive_comp.sv
module overdrive_comp
  import odc_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int LOW_W  = 6,
  parameter int NCOMP  = 3,
  parameter int IDX_W  = 4,
  parameter int LUT_W  = 10
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               enIn,
  input  logic                               depth6In,
  input  logic                               deIn,
  input  logic                               hsIn,
  input  logic                               vsIn,
  input  logic [NCOMP*COMP_W-1:0]            curPix,
  input  logic [NCOMP*COMP_W-1:0]            prevPix,
  output logic [NCOMP*CORNERS*2*IDX_W-1:0]   lutAddr,
  input  logic [NCOMP*CORNERS*LUT_W-1:0]     lutData,
  output logic                               deOut,
  output logic                               hsOut,
  output logic                               vsOut,
  output logic [NCOMP*COMP_W-1:0]            outPix
);
  odc_stb_t stb1, stb2;

  odc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enIn(enIn), .depth6In(depth6In),
    .deIn(deIn), .hsIn(hsIn), .vsIn(vsIn),
    .stb1(stb1), .stb2(stb2),
    .deOut(deOut), .hsOut(hsOut), .vsOut(vsOut)
  );

  odc_datapath #(
    .COMP_W(COMP_W), .LOW_W(LOW_W), .NCOMP(NCOMP), .IDX_W(IDX_W), .LUT_W(LUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb1(stb1), .stb2(stb2),
    .curPix(curPix), .prevPix(prevPix),
    .lutAddr(lutAddr), .lutData(lutData), .outPix(outPix)
  );
endmodule

// File: rtl/odc_checker.sv
module odc_checker #(
  parameter int COMP_W = 8,
  parameter int LOW_W  = 6,
  parameter int NCOMP  = 3,
  parameter int IDX_W  = 4,
  parameter int LUT_W  = 10
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               enIn,
  input logic                               depth6In,
  input logic                               deIn,
  input logic                               hsIn,
  input logic                               vsIn,
  input logic [NCOMP*COMP_W-1:0]            curPix,
  input logic [NCOMP*COMP_W-1:0]            prevPix,
  input logic [NCOMP*4*2*IDX_W-1:0]         lutAddr,
  input logic [NCOMP*4*LUT_W-1:0]           lutData,
  input logic                               deOut,
  input logic                               hsOut,
  input logic                               vsOut,
  input logic [NCOMP*COMP_W-1:0]            outPix
);
  localparam int PIX_W = NCOMP * COMP_W;

  function automatic logic [PIX_W-1:0] lowMask();
    logic [PIX_W-1:0] m = '0;
    for (int k = 0; k < NCOMP; k++)
      for (int b = 0; b < LOW_W; b++) m[k*COMP_W + b] = 1'b1;
    return m;
  endfunction
  localparam logic [PIX_W-1:0] LOW_MASK = lowMask();

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (deOut == $past(deIn, 3) && hsOut == $past(hsIn, 3)
                         && vsOut == $past(vsIn, 3))); // R1

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !deOut |-> (outPix == '0)); // R2

  AST_EQUAL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && $past(deIn, 3) && !$past(depth6In, 3)
     && $past(curPix, 3) == $past(prevPix, 3)) |-> (outPix == $past(curPix, 3))); // R6

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && !$past(enIn, 3) && $past(deIn, 3) && !$past(depth6In, 3))
      |-> (outPix == $past(curPix, 3))); // R7

  AST_SIX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && $past(depth6In, 3)) |-> ((outPix & ~LOW_MASK) == '0)); // R9
endmodule

bind overdrive_comp odc_checker #(
  .COMP_W(COMP_W), .LOW_W(LOW_W), .NCOMP(NCOMP), .IDX_W(IDX_W), .LUT_W(LUT_W)
) u_chk (.*);

// File: tb/overdrive_comp_tb.sv
`timescale 1ns/1ps
module overdrive_comp_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0, depth6In = 1'b0, deIn = 1'b0, hsIn = 1'b0, vsIn = 1'b0;
  logic [23:0]  curPix = '0, prevPix = '0;
  logic [95:0]  lutAddr;
  logic [119:0] lutData;
  logic deOut, hsOut, vsOut;
  logic [23:0] outPix;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  overdrive_comp u_dut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .depth6In(depth6In),
    .deIn(deIn), .hsIn(hsIn), .vsIn(vsIn),
    .curPix(curPix), .prevPix(prevPix),
    .lutAddr(lutAddr), .lutData(lutData),
    .deOut(deOut), .hsOut(hsOut), .vsOut(vsOut), .outPix(outPix)
  );

  // grid content: node (p,c) = 17*c + 12*(c-p), reaching beyond 0..255
  function automatic int gridVal(int p, int c);
    return 17 * c + 12 * (c - p);
  endfunction

  always_comb begin
    for (int n = 0; n < 12; n++) begin
      int v;
      v = gridVal(int'(lutAddr[n*8+4 +: 4]), int'(lutAddr[n*8 +: 4]));
      lutData[n*10 +: 10] = v[9:0];
    end
  end

  function automatic int normv(logic [7:0] x, bit m6);
    return m6 ? int'({x[5:0], 2'b00}) : int'(x);
  endfunction

  function automatic logic [7:0] expComp(logic [7:0] cur, logic [7:0] prv,
                                         bit m6, bit pass, bit de);
    int cn, pn, pi, ci, pi1, ci1, fp, fc, top, bot, acc, r;
    if (!de) return 8'h00;
    cn = normv(cur, m6);
    pn = normv(prv, m6);
    if (pass || cn == pn) r = cn;
    else begin
      pi = pn >> 4; ci = cn >> 4; fp = pn & 15; fc = cn & 15;
      pi1 = (pi == 15) ? 15 : pi + 1;
      ci1 = (ci == 15) ? 15 : ci + 1;
      top = gridVal(pi, ci) * (16 - fc) + gridVal(pi, ci1) * fc;
      bot = gridVal(pi1, ci) * (16 - fc) + gridVal(pi1, ci1) * fc;
      acc = top * (16 - fp) + bot * fp;
      r = (acc + 128) >>> 8;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
    end
    if (m6) r = r >> 2;
    return r[7:0];
  endfunction

  function automatic logic [95:0] expAddr(logic [23:0] cur, logic [23:0] prv, bit m6);
    logic [95:0] a;
    for (int k = 0; k < 3; k++) begin
      int cn, pn, pi, ci, pi1, ci1;
      cn = normv(cur[k*8 +: 8], m6);
      pn = normv(prv[k*8 +: 8], m6);
      pi = pn >> 4; ci = cn >> 4;
      pi1 = (pi == 15) ? 15 : pi + 1;
      ci1 = (ci == 15) ? 15 : ci + 1;
      a[(k*4+0)*8 +: 8] = 8'(pi * 16 + ci);
      a[(k*4+1)*8 +: 8] = 8'(pi1 * 16 + ci);
      a[(k*4+2)*8 +: 8] = 8'(pi * 16 + ci1);
      a[(k*4+3)*8 +: 8] = 8'(pi1 * 16 + ci1);
    end
    return a;
  endfunction

  typedef struct {
    bit          valid;
    logic [23:0] pix;
    logic [95:0] addr;
    logic        de, hs, vs;
    string       tag;
  } hist_t;
  hist_t hist [3];
  bit armedM = 0, vsPrevM = 0;

  task automatic check(bit ok, string req, string what, logic [95:0] act, logic [95:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // one clock of streaming: check what is due, then drive the next pixel
  task automatic step(bit de, bit hs, bit vs, bit en, bit m6,
                      logic [23:0] cur, logic [23:0] prv, string tag);
    hist_t h;
    bit pass;
    @(negedge clk);
    if (hist[0].valid)
      check(lutAddr == hist[0].addr, "R3", "lutAddr", lutAddr, hist[0].addr);
    if (hist[2].valid) begin
      check(outPix == hist[2].pix, hist[2].tag, "outPix", 96'(outPix), 96'(hist[2].pix));
      check({deOut, hsOut, vsOut} == {hist[2].de, hist[2].hs, hist[2].vs}, "R1", "sync",
            96'({deOut, hsOut, vsOut}), 96'({hist[2].de, hist[2].hs, hist[2].vs}));
    end
    hist[2] = hist[1];
    hist[1] = hist[0];
    pass = !en || !armedM;
    h.valid = 1;
    h.de = de; h.hs = hs; h.vs = vs; h.tag = tag;
    h.addr = expAddr(cur, prv, m6);
    for (int k = 0; k < 3; k++)
      h.pix[k*8 +: 8] = expComp(cur[k*8 +: 8], prv[k*8 +: 8], m6, pass, de);
    hist[0] = h;
    if (vs && !vsPrevM) armedM = 1;
    vsPrevM = vs;
    deIn = de; hsIn = hs; vsIn = vs; enIn = en; depth6In = m6;
    curPix = cur; prevPix = prv;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 24'h0, 24'h0, tag);
  endtask

  task automatic t_reset();
    deIn = 1; hsIn = 1; vsIn = 1; curPix = 24'hABCDEF;
    repeat (3) @(negedge clk);
    check({deOut, hsOut, vsOut} == 3'b000 && outPix == '0, "R10", "reset outputs",
          96'({deOut, hsOut, vsOut, outPix}), 96'(0));
    deIn = 0; hsIn = 0; vsIn = 0; curPix = '0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_first_frame();
    // R8: no vertical sync yet, so unequal pairs pass unchanged
    step(1, 0, 0, 1, 0, 24'h48A0F3, 24'h203070, "R8");
    step(1, 0, 0, 1, 0, 24'hFF0010, 24'h00FF80, "R8");
    step(0, 1, 0, 1, 0, 24'h0, 24'h0, "R1");
    step(0, 0, 1, 1, 0, 24'h0, 24'h0, "R8");   // frame start
    step(0, 0, 1, 1, 0, 24'h0, 24'h0, "R1");
    step(0, 0, 0, 1, 0, 24'h0, 24'h0, "R1");
  endtask

  task automatic t_interp();
    step(1, 0, 0, 1, 0, 24'h48A0F3, 24'h203070, "R4");
    step(1, 0, 0, 1, 0, 24'h1357C9, 24'h8E2A66, "R4");
    step(1, 1, 0, 1, 0, 24'h7F8001, 24'h807F02, "R4");
    step(1, 0, 0, 1, 0, 24'hF4F8FC, 24'hE1D2C3, "R3");
  endtask

  task automatic t_clamp();
    step(1, 0, 0, 1, 0, 24'hFF00F0, 24'h00FF0F, "R5");
    step(1, 0, 0, 1, 0, 24'h00FFE8, 24'hFF0008, "R5");
  endtask

  task automatic t_equal();
    step(1, 0, 0, 1, 0, 24'h5A5A5A, 24'h5A5A5A, "R6");
    step(1, 0, 0, 1, 0, 24'h00FF37, 24'h00FF37, "R6");
  endtask

  task automatic t_enable();
    step(1, 0, 0, 0, 0, 24'hFF0010, 24'h00FF80, "R7");
    step(1, 0, 0, 0, 0, 24'h48A0F3, 24'h203070, "R7");
    step(1, 0, 0, 1, 0, 24'h48A0F3, 24'h203070, "R7");
  endtask

  task automatic t_mode6();
    step(1, 0, 0, 1, 1, 24'hC03F15, 24'h00002A, "R9");  // upper bits junk
    step(1, 0, 0, 1, 1, 24'hFF3F00, 24'h00003F, "R9");
    step(1, 0, 0, 1, 1, 24'h3F80C7, 24'hBF0007, "R9");  // equal once masked
    step(1, 0, 0, 0, 1, 24'hFFEEDD, 24'h112233, "R9");
  endtask

  task automatic t_blank();
    step(0, 1, 0, 1, 0, 24'h48A0F3, 24'h203070, "R2");
    step(0, 0, 1, 1, 0, 24'hFFFFFF, 24'h000000, "R2");
    step(0, 0, 0, 0, 1, 24'hFFFFFF, 24'hFFFFFF, "R2");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) hist[i].valid = 0;
    t_reset();
    t_first_frame();
    t_interp();
    t_clamp();
    t_equal();
    t_enable();
    t_mode6();
    t_blank();
    idle(4, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule